// File: doc/BRIEF.md
# Ping-Pong Sector Transfer Engine

This block moves one error-corrected sector at a time between a byte-wide flash data stream and one of two on-chip sector buffers. Each buffer has a four-byte spare word that travels with the sector. Software writes direction and buffer choice into a control word, launches the transfer with a start bit, and polls a ready bit. While the engine works on one buffer, the processor fills or drains the other one. Successive sectors therefore alternate between the buffers.

A sector frame is made of `SECTOR_BYTES` data bytes followed by the four spare bytes. On a write, the frame is sent out of the chosen buffer. On a read, the frame is stored into the chosen buffer. The error-correction codec sits outside the block and shows up only as a status input. At the end of every read transfer, the engine latches that status into the half of the status word that belongs to the buffer just filled.

Top module: `spp_sector_xfer`

## Requirements
- R1: After reset, the control word (0x10) reads 0x0010_0000, with only the ready flag in bit 20 set. The status word (0x150) reads 0, and `nand_out_valid` is low.
- R2: A control write stores these fields, and they read back at the same positions:
  - direction in bit 1 (0 = read, 1 = write)
  - transfer enable in bit 3
  - buffer select in bit 4
  - count enable in bit 5
  - auto-correct in bit 10
  - mixed-mode in bit 29

  Bits 0 and 2 always read 0.
- R3: A control write with both bit 2 and bit 3 set, made while idle, launches a transfer. Ready (bit 20) reads 0 from the next cycle until the transfer ends. A write with bit 2 set but bit 3 clear launches nothing.
- R4: In write direction, the engine presents bytes on `nand_out_data` in this order:
  - the data bytes of the selected buffer, in ascending byte address, with byte 0 of each word in bits 7:0;
  - then the four spare bytes, low byte first.

  A byte advances only in a cycle where `nand_out_ready` is high.
- R5: In read direction, each byte accepted with `nand_in_valid` is stored in that same order into the selected buffer and then its spare word.
- R6: A transfer ends after exactly `SECTOR_BYTES`+4 bytes have moved, and ready then reads 1. Once idle, no byte is sent and no input byte is stored.
- R7: The processor accesses the buffers and spare words at these addresses:
  - buffer 0 words start at 0x1000;
  - buffer 1 words start at 0x1000+`SECTOR_BYTES`;
  - the spare words are at 0x200 (buffer 0) and 0x204 (buffer 1).

  The idle buffer can be written and read while a transfer runs on the other buffer.
- R8: The status word reports buffer 0 in bit 2 (uncorrectable) and bits 9:3 (corrected count), and buffer 1 in bit 18 and bits 25:19. The end of a read transfer latches `bch_fail`/`bch_fixed` into the half for that buffer only.
- R9: Write transfers leave the status word unchanged.
- R10: A control write made while a transfer is busy, start or not, changes no stored field. The running transfer completes unchanged.
- R11: A control write with bit 0 set aborts any transfer at once, so ready reads 1 and output stops. The other bits of that write are ignored. The next start begins again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register/buffer write strobe |
| cpu_addr | input | ADDR_W | Byte address of the 32-bit word accessed |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` (combinational) |
| nand_in_valid | input | 1 | Incoming flash byte valid (read direction) |
| nand_in_data | input | 8 | Incoming flash byte |
| nand_out_valid | output | 1 | Outgoing flash byte valid (write direction) |
| nand_out_data | output | 8 | Outgoing flash byte |
| nand_out_ready | input | 1 | Flash side accepts the outgoing byte |
| bch_fail | input | 1 | Codec verdict: sector uncorrectable |
| bch_fixed | input | 7 | Codec verdict: number of corrected bits |

## Verification
Outgoing sectors are drawn while `nand_out_ready` stalls in a repeating pattern, and incoming sectors arrive with gaps in `nand_in_valid`. Together these show that the byte order and the frame length do not depend on handshake timing.

Reads into buffer 1 and then buffer 0 carry different codec verdicts. This separates the two status halves, and a later write transfer with a changed verdict on the inputs shows that the status is captured on reads only. A sector read into a buffer is written back out of it, which confirms that the stored and emitted byte orders agree. Control writes made while busy, and an abort in mid-sector followed by a restart, show that a running transfer cannot be redirected and that the byte counter restarts at 0.

// File: rtl/spp_pkg.sv
package spp_pkg;

  localparam int NBUF        = 2;
  localparam int SPARE_BYTES = 4;
  localparam int BCH_CNT_W   = 7;

  localparam int CTL_RST   = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_START = 2;
  localparam int CTL_EN    = 3;
  localparam int CTL_BUF   = 4;
  localparam int CTL_CNTEN = 5;
  localparam int CTL_ACORR = 10;
  localparam int CTL_RDY   = 20;
  localparam int CTL_MIX   = 29;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic      mix;
    logic      acorr;
    logic      cnt_en;
    logic      buf_sel;
    logic      en;
    xfer_dir_e dir;
  } xfer_cfg_t;

  typedef struct packed {
    logic                 fail;
    logic [BCH_CNT_W-1:0] fixed;
  } bch_stat_t;

endpackage

// File: rtl/spp_ctrl_regs.sv
module spp_ctrl_regs
  import spp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        busy,
  output xfer_cfg_t   cfg,
  output logic        start,
  output logic        abort
);

  xfer_cfg_t cfg_q, cfg_d;
  logic      cfg_ld;

  assign abort  = wr_en & wdata[CTL_RST];
  assign cfg_ld = wr_en & ~wdata[CTL_RST] & ~busy;
  assign start  = cfg_ld & wdata[CTL_START] & wdata[CTL_EN];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_ld) begin
      cfg_d.dir     = xfer_dir_e'(wdata[CTL_DIR]);
      cfg_d.en      = wdata[CTL_EN];
      cfg_d.buf_sel = wdata[CTL_BUF];
      cfg_d.cnt_en  = wdata[CTL_CNTEN];
      cfg_d.acorr   = wdata[CTL_ACORR];
      cfg_d.mix     = wdata[CTL_MIX];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R10: configuration frozen while a transfer runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));

  // R2: a load needs an idle engine
  p_cfg_idle_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> !$past(busy));

endmodule

// File: rtl/spp_xfer_seq.sv
module spp_xfer_seq
  import spp_pkg::*;
#(
  parameter int SECTOR_BYTES = 1024,
  localparam int FRAME = SECTOR_BYTES + SPARE_BYTES,
  localparam int CNT_W = $clog2(FRAME)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  xfer_dir_e        dir_in,
  input  logic             buf_in,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             busy,
  output xfer_dir_e        act_dir,
  output logic             act_buf,
  output logic [CNT_W-1:0] cnt,
  output logic             fire,
  output logic             done
);

  logic             busy_q, busy_d;
  xfer_dir_e        dir_q, dir_d;
  logic             buf_q, buf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == CNT_W'(FRAME - 1));
  assign fire = busy_q & ~abort & ((dir_q == DIR_WR) ? out_ready : in_valid);
  assign done = fire & last;

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      dir_d  = dir_in;
      buf_d  = buf_in;
      cnt_d  = '0;
    end else if (fire) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_RD;
      buf_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign act_dir = dir_q;
  assign act_buf = buf_q;
  assign cnt     = cnt_q;

  // R6: byte counter never passes the frame
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(FRAME)));

  // R6: engine idles after the final byte
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R3: accepted start makes the engine busy from byte 0
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && !abort) |=> (busy_q && cnt_q == '0));

  // R10: buffer and direction hold during a transfer
  p_target_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !abort && !done) |=> ($stable(buf_q) && $stable(dir_q)));

  // R11: abort returns to idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q);

endmodule

// File: rtl/spp_sector_store.sv
module spp_sector_store
  import spp_pkg::*;
#(
  parameter int SECTOR_BYTES = 1024,
  localparam int WORDS   = SECTOR_BYTES / 4,
  localparam int SEC_AW  = $clog2(SECTOR_BYTES),
  localparam int WORD_AW = SEC_AW - 2,
  localparam int CNT_W   = $clog2(SECTOR_BYTES + SPARE_BYTES)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_buf_we,
  input  logic                    cpu_buf_sel,
  input  logic [WORD_AW-1:0]      cpu_word,
  input  logic [31:0]             cpu_wdata,
  output logic [31:0]             cpu_buf_rdata,
  input  logic [NBUF-1:0]         cpu_spare_we,
  output logic [NBUF-1:0][31:0]   spare_o,
  input  logic                    eng_buf,
  input  logic [CNT_W-1:0]        eng_idx,
  input  logic                    eng_we,
  input  logic [7:0]              eng_wbyte,
  output logic [7:0]              eng_rbyte
);

  logic [3:0][7:0] mem_q [NBUF*WORDS];
  logic [3:0][7:0] spare_q [NBUF];

  logic               eng_in_spare;
  logic [WORD_AW-1:0] eng_word;
  logic [1:0]         eng_lane;

  assign eng_in_spare = eng_idx[SEC_AW];
  assign eng_word     = eng_idx[SEC_AW-1:2];
  assign eng_lane     = eng_idx[1:0];

  always_ff @(posedge clk) begin
    if (cpu_buf_we)
      mem_q[{cpu_buf_sel, cpu_word}] <= cpu_wdata;
    if (eng_we && !eng_in_spare)
      mem_q[{eng_buf, eng_word}][eng_lane] <= eng_wbyte;
  end

  assign cpu_buf_rdata = mem_q[{cpu_buf_sel, cpu_word}];

  for (genvar g = 0; g < NBUF; g++) begin : g_spare
    logic eng_hit;
    assign eng_hit = eng_we & eng_in_spare & (eng_buf == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               spare_q[g] <= '0;
      else if (eng_hit)         spare_q[g][eng_lane] <= eng_wbyte;
      else if (cpu_spare_we[g]) spare_q[g] <= cpu_wdata;
    end

    assign spare_o[g] = spare_q[g];

    // R7: spare word only changes through an engine or processor write
    p_spare_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_hit && !cpu_spare_we[g]) |=> $stable(spare_q[g]));
  end

  assign eng_rbyte = eng_in_spare ? spare_q[eng_buf][eng_lane]
                                  : mem_q[{eng_buf, eng_word}][eng_lane];

endmodule

// File: rtl/spp_bch_status.sv
module spp_bch_status
  import spp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic        cap_buf,
  input  bch_stat_t   stat_in,
  output logic [31:0] stat_word
);

  bch_stat_t stat_q [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_half
    logic hit;
    assign hit = cap_en & (cap_buf == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stat_q[g] <= '0;
      else if (hit) stat_q[g] <= stat_in;
    end
  end

  always_comb begin
    stat_word = '0;
    for (int g = 0; g < NBUF; g++) begin
      stat_word[16*g + 2]            = stat_q[g].fail;
      stat_word[16*g + 3 +: BCH_CNT_W] = stat_q[g].fixed;
    end
  end

  // R9: status word changes only on a capture
  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(stat_word));

  // R8: a capture touches only its own half
  p_half_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_buf) |=> $stable(stat_word[31:16]));

endmodule

// File: rtl/spp_sector_xfer.sv
module spp_sector_xfer
  import spp_pkg::*;
#(
  parameter int SECTOR_BYTES = 1024,
  parameter int ADDR_W       = 13,
  localparam int SEC_AW  = $clog2(SECTOR_BYTES),
  localparam int WORD_AW = SEC_AW - 2,
  localparam int CNT_W   = $clog2(SECTOR_BYTES + SPARE_BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              nand_in_valid,
  input  logic [7:0]        nand_in_data,
  output logic              nand_out_valid,
  output logic [7:0]        nand_out_data,
  input  logic              nand_out_ready,
  input  logic              bch_fail,
  input  logic [6:0]        bch_fixed
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(32'h010);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(32'h150);
  localparam logic [ADDR_W-1:0] A_SPARE0 = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] A_SPARE1 = ADDR_W'(32'h204);
  localparam logic [ADDR_W-1:0] A_BUF    = ADDR_W'(32'h1000);

  logic hit_ctrl, hit_stat, hit_buf;
  logic [NBUF-1:0] hit_spare;

  assign hit_ctrl     = (cpu_addr == A_CTRL);
  assign hit_stat     = (cpu_addr == A_STAT);
  assign hit_spare[0] = (cpu_addr == A_SPARE0);
  assign hit_spare[1] = (cpu_addr == A_SPARE1);
  assign hit_buf      = (cpu_addr[ADDR_W-1:SEC_AW+1] == A_BUF[ADDR_W-1:SEC_AW+1]);

  xfer_cfg_t        cfg;
  logic             start, abort;
  logic             busy, act_buf, fire, done;
  xfer_dir_e        act_dir;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      buf_rdata, stat_word;
  logic [NBUF-1:0][31:0] spare_w;
  logic [7:0]       eng_rbyte;
  bch_stat_t        bch_in;

  spp_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cpu_wr & hit_ctrl),
    .wdata (cpu_wdata),
    .busy  (busy),
    .cfg   (cfg),
    .start (start),
    .abort (abort)
  );

  spp_xfer_seq #(.SECTOR_BYTES(SECTOR_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .dir_in    (xfer_dir_e'(cpu_wdata[CTL_DIR])),
    .buf_in    (cpu_wdata[CTL_BUF]),
    .in_valid  (nand_in_valid),
    .out_ready (nand_out_ready),
    .busy      (busy),
    .act_dir   (act_dir),
    .act_buf   (act_buf),
    .cnt       (cnt),
    .fire      (fire),
    .done      (done)
  );

  spp_sector_store #(.SECTOR_BYTES(SECTOR_BYTES)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_buf_we    (cpu_wr & hit_buf),
    .cpu_buf_sel   (cpu_addr[SEC_AW]),
    .cpu_word      (cpu_addr[SEC_AW-1:2]),
    .cpu_wdata     (cpu_wdata),
    .cpu_buf_rdata (buf_rdata),
    .cpu_spare_we  ({NBUF{cpu_wr}} & hit_spare),
    .spare_o       (spare_w),
    .eng_buf       (act_buf),
    .eng_idx       (cnt),
    .eng_we        (fire & (act_dir == DIR_RD)),
    .eng_wbyte     (nand_in_data),
    .eng_rbyte     (eng_rbyte)
  );

  assign bch_in.fail  = bch_fail;
  assign bch_in.fixed = bch_fixed;

  spp_bch_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (done & (act_dir == DIR_RD)),
    .cap_buf   (act_buf),
    .stat_in   (bch_in),
    .stat_word (stat_word)
  );

  assign nand_out_valid = busy & (act_dir == DIR_WR);
  assign nand_out_data  = eng_rbyte;

  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CTL_DIR]   = cfg.dir;
    ctrl_rd[CTL_EN]    = cfg.en;
    ctrl_rd[CTL_BUF]   = cfg.buf_sel;
    ctrl_rd[CTL_CNTEN] = cfg.cnt_en;
    ctrl_rd[CTL_ACORR] = cfg.acorr;
    ctrl_rd[CTL_RDY]   = ~busy;
    ctrl_rd[CTL_MIX]   = cfg.mix;
  end

  always_comb begin
    cpu_rdata = '0;
    if (hit_ctrl)          cpu_rdata = ctrl_rd;
    else if (hit_stat)     cpu_rdata = stat_word;
    else if (hit_spare[0]) cpu_rdata = spare_w[0];
    else if (hit_spare[1]) cpu_rdata = spare_w[1];
    else if (hit_buf)      cpu_rdata = buf_rdata;
  end

  // R4: an outgoing byte is never dropped while stalled
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_out_valid && !nand_out_ready && !abort) |=> (nand_out_valid && $stable(cnt)));

endmodule

// File: tb/spp_sector_xfer_tb_top.sv
module spp_sector_xfer_tb_top;

  localparam int SB = 1024;
  localparam int FR = SB + 4;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_wr;
  logic [AW-1:0] cpu_addr;
  logic [31:0]   cpu_wdata;
  logic [31:0]   cpu_rdata;
  logic          nand_in_valid;
  logic [7:0]    nand_in_data;
  logic          nand_out_valid;
  logic [7:0]    nand_out_data;
  logic          nand_out_ready;
  logic          bch_fail;
  logic [6:0]    bch_fixed;

  always #10 clk = ~clk;

  spp_sector_xfer #(.SECTOR_BYTES(SB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .nand_in_valid(nand_in_valid), .nand_in_data(nand_in_data),
    .nand_out_valid(nand_out_valid), .nand_out_data(nand_out_data),
    .nand_out_ready(nand_out_ready), .bch_fail(bch_fail), .bch_fixed(bch_fixed)
  );

  int n_chk = 0;
  int n_fail = 0;
  int out_seen = 0;
  bit mon_on = 1'b1;
  logic [7:0] exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wval(int b, int i, int s);
    return (32'(s) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B1) ^ (32'(b) << 28);
  endfunction

  function automatic logic [7:0] rbyte(int k, int s);
    logic [31:0] v;
    v = 32'(k) * 7 + 32'(s) * 13 + (32'(k) >> 8);
    return v[7:0];
  endfunction

  task automatic cpu_write(int a, logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(int a, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = AW'(a);
    #2 d = cpu_rdata;
  endtask

  task automatic fill_buf(int b, int s);
    for (int i = 0; i < SB/4; i++) cpu_write(32'h1000 + b*SB + 4*i, wval(b, i, s));
    cpu_write(32'h200 + 4*b, wval(b, 999, s));
  endtask

  task automatic push_wbuf(int b, int s);
    logic [31:0] w;
    for (int i = 0; i < SB; i++) begin
      w = wval(b, i/4, s);
      exp_q.push_back(w[8*(i%4) +: 8]);
    end
    w = wval(b, 999, s);
    for (int i = 0; i < 4; i++) exp_q.push_back(w[8*i +: 8]);
  endtask

  task automatic wait_ready();
    logic [31:0] d;
    for (int n = 0; n < 4*FR; n++) begin
      cpu_read(32'h10, d);
      if (d[20]) return;
    end
    chk("R6 ready never set", 32'(d[20]), 32'd1);
  endtask

  task automatic send_frame(int s);
    int k = 0;
    int t = 0;
    while (k < FR) begin
      @(negedge clk);
      t++;
      if (t % 4 == 0) nand_in_valid = 1'b0;
      else begin nand_in_valid = 1'b1; nand_in_data = rbyte(k, s); k++; end
    end
    @(negedge clk);
    nand_in_valid = 1'b0;
  endtask

  task automatic junk_bytes();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); nand_in_valid = 1'b1; nand_in_data = 8'hA5;
    end
    @(negedge clk); nand_in_valid = 1'b0;
  endtask

  task automatic check_rbuf(string tag, int b, int s);
    logic [31:0] d;
    for (int i = 0; i < SB/4; i++) begin
      cpu_read(32'h1000 + b*SB + 4*i, d);
      chk(tag, d, {rbyte(4*i+3, s), rbyte(4*i+2, s), rbyte(4*i+1, s), rbyte(4*i, s)});
    end
    cpu_read(32'h200 + 4*b, d);
    chk({tag, " spare"}, d, {rbyte(SB+3, s), rbyte(SB+2, s), rbyte(SB+1, s), rbyte(SB, s)});
  endtask

  // stall pattern on the outgoing handshake
  initial begin
    int c = 0;
    nand_out_ready = 1'b0;
    forever begin
      @(negedge clk);
      c++;
      nand_out_ready = (c % 5 != 3);
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n === 1'b1 && nand_out_valid && nand_out_ready) begin
        out_seen++;
        if (mon_on) begin
          if (exp_q.size() == 0) chk("R6 byte beyond frame", 32'(nand_out_data), 32'hFFFF_FFFF);
          else chk("R4 outgoing byte", 32'(nand_out_data), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    nand_in_valid = 1'b0; nand_in_data = '0; bch_fail = 1'b0; bch_fixed = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cpu_read(32'h10, d);  chk("R1 ctrl after reset", d, 32'h0010_0000);
    cpu_read(32'h150, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 out_valid after reset", 32'(nand_out_valid), 32'h0);

    // R2 field storage, R3 start without enable
    cpu_write(32'h10, 32'h2000_043A);
    cpu_read(32'h10, d); chk("R2 field readback", d, 32'h2010_043A);
    cpu_write(32'h10, 32'h2000_0434);
    repeat (3) @(negedge clk);
    cpu_read(32'h10, d); chk("R3 start without enable ignored", d, 32'h2010_0430);
    chk("R3 no output without enable", 32'(nand_out_valid), 32'h0);

    // R4 R3 R6 write transfer from buffer 0
    fill_buf(0, 1);
    push_wbuf(0, 1);
    out_seen = 0;
    cpu_write(32'h10, 32'h0000_000A);
    cpu_write(32'h10, 32'h0000_000E);
    cpu_read(32'h10, d); chk("R3 ready low after start", 32'(d[20]), 32'h0);
    wait_ready();
    repeat (8) @(negedge clk);
    chk("R6 frame length out", out_seen, FR);
    chk("R4 queue drained", exp_q.size(), 0);

    // R5 R7 R8 read into buffer 1 while filling buffer 0
    bch_fail = 1'b0; bch_fixed = 7'd5;
    cpu_write(32'h10, 32'h0000_0018);
    cpu_write(32'h10, 32'h0000_001C);
    fork
      send_frame(2);
      fill_buf(0, 3);
    join
    wait_ready();
    junk_bytes();
    check_rbuf("R5 read into buffer 1", 1, 2);
    for (int i = 0; i < SB/4; i++) begin
      cpu_read(32'h1000 + 4*i, d); chk("R7 idle buffer 0 filled", d, wval(0, i, 3));
    end
    cpu_read(32'h200, d); chk("R7 spare 0 filled", d, wval(0, 999, 3));
    cpu_read(32'h150, d); chk("R8 buffer 1 status", d, 32'h0028_0000);

    // R8 read into buffer 0 with uncorrectable verdict
    bch_fail = 1'b1; bch_fixed = 7'h7F;
    cpu_write(32'h10, 32'h0000_0008);
    cpu_write(32'h10, 32'h0000_000C);
    send_frame(4);
    wait_ready();
    check_rbuf("R5 read into buffer 0", 0, 4);
    cpu_read(32'h150, d); chk("R8 both halves", d, 32'h0028_03FC);

    // R9 R10 write from buffer 1, control write while busy
    bch_fail = 1'b0; bch_fixed = 7'd9;
    for (int k = 0; k < FR; k++) exp_q.push_back(rbyte(k, 2));
    out_seen = 0;
    cpu_write(32'h10, 32'h0000_001A);
    cpu_write(32'h10, 32'h0000_001E);
    repeat (20) @(negedge clk);
    cpu_write(32'h10, 32'h2000_000C);
    cpu_read(32'h10, d); chk("R10 fields held while busy", d, 32'h0000_001A);
    wait_ready();
    repeat (8) @(negedge clk);
    chk("R10 transfer completed unchanged", out_seen, FR);
    chk("R10 queue drained", exp_q.size(), 0);
    cpu_read(32'h150, d); chk("R9 status after write transfer", d, 32'h0028_03FC);

    // R11 abort and restart
    mon_on = 1'b0;
    cpu_write(32'h10, 32'h0000_000A);
    cpu_write(32'h10, 32'h0000_000E);
    repeat (40) @(negedge clk);
    cpu_write(32'h10, 32'h0000_0001);
    cpu_read(32'h10, d); chk("R11 ready after abort", d, 32'h0010_000A);
    repeat (3) @(negedge clk);
    #5 chk("R11 output stopped", 32'(nand_out_valid), 32'h0);
    mon_on = 1'b1;
    for (int k = 0; k < FR; k++) exp_q.push_back(rbyte(k, 4));
    out_seen = 0;
    cpu_write(32'h10, 32'h0000_000E);
    wait_ready();
    repeat (8) @(negedge clk);
    chk("R11 restart full frame", out_seen, FR);
    chk("R11 queue drained", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule